// File: doc/BRIEF.md
# Floating-point status register update unit

This block owns the 32-bit status and control word of a floating-point unit. Each cycle it may take one completion report from the arithmetic pipeline and one explicit status command. A completion report carries exception strobes, a result class and sign, the rounded-up and inexact indications and the kind of operation that finished. A command sets or clears one bit, loads the whole word, or copies one 4-bit field out to a side register.

The unit keeps the exception bits sticky and keeps three summary bits up to date. The first, the any-exception summary at bit 31, is set whenever some individual exception bit turns from 0 to 1. The second, the enabled-exception summary, and the third, the invalid-operation summary, are always derived from the other bits and cannot be written. Each operation kind has its own rule for the rounded-up bit, the inexact bit and the result-flag field. Bit 11 is reserved and always reads as zero.

Top module: `fpstat_unit`

## Requirements
- R1: After reset `csr_o`, `field_o`, `exc_sum_o` and `inv_sum_o` are all zero.
- R2: Strobe `op_raise[i]` of an accepted report (op_kind 0, 1, 3, 4 or 5) sets an exception bit at these positions, for i = 0..12: 24 signalling NaN, 23 inf-inf, 22 inf/inf, 21 zero/zero, 20 inf*zero, 19 invalid compare, 10 software request, 9 invalid square root, 8 invalid integer convert, 28 overflow, 27 underflow, 26 divide by zero, 25 inexact. These bits stay set until a clear-bit or load-word command changes them.
- R3: Bit 31 is set in the cycle that any of the 13 exception bits goes from 0 to 1, even when bit 29 is already 1. Raising a bit that is already set leaves bit 31 unchanged.
- R4: Bit 29 (`inv_sum_o`) is the OR of the nine invalid bits. Bit 30 is the OR of (bit 29 AND bit 7), (28 AND 6), (27 AND 5), (26 AND 4) and (25 AND 3). Set, clear and load commands have no direct effect on bits 29 and 30.
- R5: Bit 11 always reads as 0, including after a set command on it or a load of all ones.
- R6: Command `cmd_kind`=0 sets bit `cmd_bit`. If that turns an exception bit from 0 to 1, bit 31 is set too. When a report and a command arrive in the same cycle, the command acts on the word already updated by the report.
- R7: Command 1 clears bit `cmd_bit`. Command 2 loads `cmd_data` into every bit except 29, 30 and 11, and applies no implicit rule to bit 31. The summaries are then derived again from the new bits.
- R8: Command 3 loads `field_o` from bits [4k+3:4k] of the word as it stood before that edge, with k = `cmd_field`. Bit 11 appears as 0 in field 2. `field_o` holds its value otherwise.
- R9: A select-type report (op_kind 2) leaves the whole word unchanged, and its strobes and flag inputs are ignored. Op kinds 6 and 7 do the same.
- R10: A round-to-integral report (op_kind 3) clears bits 18 and 17 and never sets the inexact bit 25. Its other strobes are applied.
- R11: Plain arithmetic (0), integer-to-float (4) and float-to-integer (5) reports replace bit 18 with `op_frac_up` and bit 17 with `op_inexact`, so no earlier value survives.
- R12: A float-to-integer report writes 0 into the result-flag field, bits 16:12.
- R13: A special-case report (op_kind 1) clears bits 18 and 17, applies its strobes and writes the result-flag field.
- R14: The result-flag field, bits 16:12, is written from `res_class` (0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN) and `res_neg` with these codes: quiet NaN 0x11 for either sign; negative infinity 0x09, normal 0x08, denormal 0x18, zero 0x12; positive zero 0x02, denormal 0x14, normal 0x04, infinity 0x05. Classes 5 to 7 write 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Completion report present |
| op_kind | input | 3 | Operation kind of the report |
| op_raise | input | 13 | Per-exception raise strobes |
| res_class | input | 3 | Result class |
| res_neg | input | 1 | Result sign (1 = negative) |
| op_frac_up | input | 1 | Fraction was rounded up |
| op_inexact | input | 1 | Result was inexact |
| cmd_valid | input | 1 | Status command present |
| cmd_kind | input | 2 | 0 set bit, 1 clear bit, 2 load word, 3 copy field |
| cmd_bit | input | 5 | Bit index for set and clear |
| cmd_field | input | 3 | Field index for copy |
| cmd_data | input | 32 | Word for load |
| csr_o | output | 32 | Status and control word |
| field_o | output | 4 | Last copied field |
| exc_sum_o | output | 1 | Any-exception summary (bit 31) |
| inv_sum_o | output | 1 | Invalid-operation summary (bit 29) |

## Verification
The hardest case to reach is the rise of a second invalid bit while the invalid summary is already 1 and bit 31 has just been cleared. In that case the summary bit does not change, so only a per-bit rule can set bit 31 again. The stimulus raises one invalid strobe, clears bit 31 with a command, and then raises the same bit again (bit 31 must stay clear) and after that a different invalid bit (bit 31 must be set). Set commands repeat the same pattern on the inexact bit. A report and a command are also issued in the same cycle.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int REG_W   = 32;
    localparam int N_EXC   = 13;
    localparam int FLAG_W  = 5;
    localparam int FIELD_W = 4;

    localparam int B_ANY   = 31;
    localparam int B_ENSUM = 30;
    localparam int B_INV   = 29;
    localparam int B_UP    = 18;
    localparam int B_INX   = 17;
    localparam int FLAG_LO = 12;
    localparam int B_RSV   = 11;
    localparam int B_VEN   = 7;

    localparam logic [REG_W-1:0] EXC_MASK = 32'h1FF8_0700;
    localparam logic [REG_W-1:0] INV_MASK = 32'h01F8_0700;
    localparam logic [REG_W-1:0] RO_MASK  = 32'h6000_0800;
    localparam logic [REG_W-1:0] RSV_MASK = 32'h0000_0800;
    localparam logic [REG_W-1:0] XX_BIT   = 32'h0200_0000;

    typedef enum logic [2:0] {
        OP_ARITH  = 3'd0,
        OP_SPEC   = 3'd1,
        OP_SELECT = 3'd2,
        OP_RNDINT = 3'd3,
        OP_I2F    = 3'd4,
        OP_F2I    = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        CMD_SET   = 2'd0,
        CMD_CLR   = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_COPY  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4
    } res_class_e;

    typedef struct packed {
        logic [REG_W-1:0]   csr;
        logic [FIELD_W-1:0] field;
    } state_t;

    function automatic int exc_pos(input int idx);
        case (idx)
            0:       return 24;
            1:       return 23;
            2:       return 22;
            3:       return 21;
            4:       return 20;
            5:       return 19;
            6:       return 10;
            7:       return 9;
            8:       return 8;
            9:       return 28;
            10:      return 27;
            11:      return 26;
            default: return 25;
        endcase
    endfunction

endpackage

// File: rtl/fpstat_class_enc.sv
module fpstat_class_enc
    import fpstat_pkg::*;
#(
    parameter int CODE_W = FLAG_W
) (
    input  logic [2:0]        cls_i,
    input  logic              neg_i,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        code_o = '0;
        case (res_class_e'(cls_i))
            CLS_QNAN:   code_o = CODE_W'(5'h11);
            CLS_INF:    code_o = neg_i ? CODE_W'(5'h09) : CODE_W'(5'h05);
            CLS_NORMAL: code_o = neg_i ? CODE_W'(5'h08) : CODE_W'(5'h04);
            CLS_DENORM: code_o = neg_i ? CODE_W'(5'h18) : CODE_W'(5'h14);
            CLS_ZERO:   code_o = neg_i ? CODE_W'(5'h12) : CODE_W'(5'h02);
            default:    code_o = '0;
        endcase
    end
endmodule

// File: rtl/fpstat_raise_map.sv
module fpstat_raise_map
    import fpstat_pkg::*;
#(
    parameter int NE = N_EXC,
    parameter int RW = REG_W
) (
    input  logic [NE-1:0] raise_i,
    output logic [RW-1:0] vec_o
);
    logic [NE-1:0][RW-1:0] part;

    for (genvar i = 0; i < NE; i++) begin : g_bit
        localparam int P = exc_pos(i);
        assign part[i] = raise_i[i] ? (RW'(1) << P) : '0;
    end

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NE; i++) begin
            vec_o = vec_o | part[i];
        end
    end
endmodule

// File: rtl/fpstat_field_mux.sv
module fpstat_field_mux
    import fpstat_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int FW = FIELD_W,
    parameter logic [RW-1:0] HIDE = RSV_MASK
) (
    input  logic [RW-1:0]                word_i,
    input  logic [$clog2(RW/FW)-1:0]     sel_i,
    output logic [FW-1:0]                field_o
);
    localparam int NF = RW / FW;

    logic [NF-1:0][FW-1:0] fields;
    logic [RW-1:0]         clean;

    assign clean = word_i & ~HIDE;

    for (genvar k = 0; k < NF; k++) begin : g_fld
        assign fields[k] = clean[k*FW +: FW];
    end

    assign field_o = fields[sel_i];
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
    import fpstat_pkg::*;
#(
    parameter int RW  = REG_W,
    parameter int NE  = N_EXC,
    parameter int FW  = FIELD_W,
    parameter int FLW = FLAG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_valid,
    input  logic [2:0]                op_kind,
    input  logic [NE-1:0]             op_raise,
    input  logic [2:0]                res_class,
    input  logic                      res_neg,
    input  logic                      op_frac_up,
    input  logic                      op_inexact,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_kind,
    input  logic [$clog2(RW)-1:0]     cmd_bit,
    input  logic [$clog2(RW/FW)-1:0]  cmd_field,
    input  logic [RW-1:0]             cmd_data,
    output logic [RW-1:0]             csr_o,
    output logic [FW-1:0]             field_o,
    output logic                      exc_sum_o,
    output logic                      inv_sum_o
);
    state_t          st_d, st_q;
    logic [RW-1:0]   raise_vec;
    logic [FLW-1:0]  flag_code;
    logic [FW-1:0]   field_w;
    logic            is_load;

    fpstat_raise_map #(.NE(NE), .RW(RW)) u_map (
        .raise_i (op_raise),
        .vec_o   (raise_vec)
    );

    fpstat_class_enc #(.CODE_W(FLW)) u_enc (
        .cls_i  (res_class),
        .neg_i  (res_neg),
        .code_o (flag_code)
    );

    fpstat_field_mux #(.RW(RW), .FW(FW), .HIDE(RSV_MASK)) u_fld (
        .word_i  (st_q.csr),
        .sel_i   (cmd_field),
        .field_o (field_w)
    );

    assign is_load = cmd_valid && (cmd_kind == CMD_WRITE);

    always_comb begin
        logic [RW-1:0] nx;
        st_d = st_q;
        nx   = st_q.csr;

        if (op_valid) begin
            case (op_kind_e'(op_kind))
                OP_ARITH, OP_I2F, OP_F2I: begin
                    nx                  = nx | raise_vec;
                    nx[B_UP]            = op_frac_up;
                    nx[B_INX]           = op_inexact;
                    nx[FLAG_LO +: FLW]  = (op_kind == OP_F2I) ? '0 : flag_code;
                end
                OP_SPEC: begin
                    nx                  = nx | raise_vec;
                    nx[B_UP]            = 1'b0;
                    nx[B_INX]           = 1'b0;
                    nx[FLAG_LO +: FLW]  = flag_code;
                end
                OP_RNDINT: begin
                    nx                  = nx | (raise_vec & ~XX_BIT);
                    nx[B_UP]            = 1'b0;
                    nx[B_INX]           = 1'b0;
                    nx[FLAG_LO +: FLW]  = flag_code;
                end
                default: ;
            endcase
        end

        if (cmd_valid) begin
            case (cmd_kind_e'(cmd_kind))
                CMD_SET:   if (!RO_MASK[cmd_bit]) nx[cmd_bit] = 1'b1;
                CMD_CLR:   if (!RO_MASK[cmd_bit]) nx[cmd_bit] = 1'b0;
                CMD_WRITE: nx = cmd_data & ~RO_MASK;
                CMD_COPY:  st_d.field = field_w;
                default: ;
            endcase
        end

        if (!is_load && (|(nx & ~st_q.csr & EXC_MASK))) begin
            nx[B_ANY] = 1'b1;
        end

        nx[B_INV]   = |(nx & INV_MASK);
        nx[B_ENSUM] = (nx[B_INV] & nx[B_VEN]) | (nx[28] & nx[6]) |
                      (nx[27] & nx[5]) | (nx[26] & nx[4]) | (nx[25] & nx[3]);
        nx[B_RSV]   = 1'b0;

        st_d.csr = nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_o     = st_q.csr;
    assign field_o   = st_q.field;
    assign exc_sum_o = st_q.csr[B_ANY];
    assign inv_sum_o = st_q.csr[B_INV];

    a_r3_any_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(csr_o & EXC_MASK & ~$past(csr_o))) && !$past(is_load)) |-> exc_sum_o);

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ((csr_o & $past(csr_o) & EXC_MASK) == ($past(csr_o) & EXC_MASK)));

    a_r9_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_SELECT && !cmd_valid) |=> $stable(csr_o));

    a_r10_rndint: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_RNDINT && !cmd_valid) |=>
            (!csr_o[B_UP] && !csr_o[B_INX] && csr_o[25] == $past(csr_o[25])));

    a_r4_inv_summary: assert property (@(posedge clk) disable iff (!rst_n)
        inv_sum_o == (|(csr_o & INV_MASK)));

    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_SET && cmd_bit == 5'd11) |=> !csr_o[B_RSV]);

endmodule

// File: tb/tb_fpstat_unit.sv
module tb_fpstat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [12:0] op_raise = '0;
    logic [2:0]  res_class = '0;
    logic        res_neg = 1'b0;
    logic        op_frac_up = 1'b0;
    logic        op_inexact = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [4:0]  cmd_bit = '0;
    logic [2:0]  cmd_field = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] csr_o;
    logic [3:0]  field_o;
    logic        exc_sum_o;
    logic        inv_sum_o;

    always #2 clk = ~clk;

    fpstat_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_raise(op_raise), .res_class(res_class), .res_neg(res_neg),
        .op_frac_up(op_frac_up), .op_inexact(op_inexact), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .cmd_field(cmd_field),
        .cmd_data(cmd_data), .csr_o(csr_o), .field_o(field_o),
        .exc_sum_o(exc_sum_o), .inv_sum_o(inv_sum_o)
    );

    typedef struct {
        logic [31:0] csr;
        logic [3:0]  fld;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [31:0] m_csr = '0;
    logic [3:0]  m_fld = '0;

    localparam int POS [13] = '{24, 23, 22, 21, 20, 19, 10, 9, 8, 28, 27, 26, 25};

    function automatic logic [4:0] flag_of(input logic [2:0] c, input logic n);
        case (c)
            3'd4: return 5'h11;
            3'd3: return n ? 5'h09 : 5'h05;
            3'd2: return n ? 5'h08 : 5'h04;
            3'd1: return n ? 5'h18 : 5'h14;
            3'd0: return n ? 5'h12 : 5'h02;
            default: return 5'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ov, input logic [2:0] ok, input logic [12:0] rz,
                         input logic [2:0] cl, input logic ng, input logic fu, input logic fi,
                         input logic cv, input logic [1:0] ck, input logic [4:0] cb,
                         input logic [2:0] cf, input logic [31:0] cd, input string tag);
        logic [31:0] c;
        logic [31:0] rv;
        logic [31:0] old;
        item_t it;
        @(negedge clk);
        op_valid = ov; op_kind = ok; op_raise = rz; res_class = cl; res_neg = ng;
        op_frac_up = fu; op_inexact = fi; cmd_valid = cv; cmd_kind = ck;
        cmd_bit = cb; cmd_field = cf; cmd_data = cd;
        old = m_csr;
        c = old;
        rv = '0;
        for (int i = 0; i < 13; i++) if (rz[i]) rv[POS[i]] = 1'b1;
        if (ov) begin
            case (ok)
                3'd0, 3'd4, 3'd5: begin
                    c = c | rv; c[18] = fu; c[17] = fi;
                    c[16:12] = (ok == 3'd5) ? 5'h00 : flag_of(cl, ng);
                end
                3'd1: begin
                    c = c | rv; c[18] = 1'b0; c[17] = 1'b0; c[16:12] = flag_of(cl, ng);
                end
                3'd3: begin
                    rv[25] = 1'b0;
                    c = c | rv; c[18] = 1'b0; c[17] = 1'b0; c[16:12] = flag_of(cl, ng);
                end
                default: ;
            endcase
        end
        if (cv) begin
            case (ck)
                2'd0: if (cb != 5'd29 && cb != 5'd30 && cb != 5'd11) c[cb] = 1'b1;
                2'd1: if (cb != 5'd29 && cb != 5'd30 && cb != 5'd11) c[cb] = 1'b0;
                2'd2: c = cd & 32'h9FFF_F7FF;
                default: m_fld = (old & 32'hFFFF_F7FF) >> (cf * 4);
            endcase
        end
        if (!(cv && ck == 2'd2) && ((c & ~old & 32'h1FF8_0700) != 0)) c[31] = 1'b1;
        c[29] = |(c & 32'h01F8_0700);
        c[30] = (c[29] & c[7]) | (c[28] & c[6]) | (c[27] & c[5]) | (c[26] & c[4]) | (c[25] & c[3]);
        c[11] = 1'b0;
        m_csr = c;
        it.csr = c; it.fld = m_fld; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic op(input logic [2:0] ok, input logic [12:0] rz, input logic [2:0] cl,
                      input logic ng, input logic fu, input logic fi, input string tag);
        drive(1'b1, ok, rz, cl, ng, fu, fi, 1'b0, 2'd0, 5'd0, 3'd0, 32'h0, tag);
    endtask

    task automatic cmd(input logic [1:0] ck, input logic [4:0] cb, input logic [2:0] cf,
                       input logic [31:0] cd, input string tag);
        drive(1'b0, 3'd0, 13'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, ck, cb, cf, cd, tag);
    endtask

    // Scoreboard monitor: compares one expected item per clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " word"}, csr_o, it.csr);
                check({it.tag, " field"}, {28'h0, field_o}, {28'h0, it.fld});
                check({it.tag, " summaries"}, {30'h0, exc_sum_o, inv_sum_o},
                      {30'h0, it.csr[31], it.csr[29]});
            end
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", csr_o, 32'h0);
        check("R1 reset field/summaries", {26'h0, field_o, exc_sum_o, inv_sum_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        op(3'd0, 13'h0001, 3'd2, 1'b0, 1'b1, 1'b1, "R2 R3 R11 snan raise");
        cmd(2'd1, 5'd31, 3'd0, 0, "R7 clear any-summary");
        op(3'd0, 13'h0001, 3'd2, 1'b0, 1'b0, 1'b0, "R3 re-raise set bit no summary");
        op(3'd0, 13'h0003, 3'd2, 1'b0, 1'b0, 1'b0, "R3 second invalid rises with VX set");
        op(3'd0, 13'h0000, 3'd2, 1'b1, 1'b1, 1'b1, "R2 sticky no raise");
        op(3'd4, 13'h0000, 3'd2, 1'b0, 1'b0, 1'b0, "R11 int-to-float clears stale");
        cmd(2'd0, 5'd7, 3'd0, 0, "R4 enable invalid sets enabled summary");
        cmd(2'd0, 5'd30, 3'd0, 0, "R4 set of enabled summary ignored");
        cmd(2'd1, 5'd29, 3'd0, 0, "R4 clear of invalid summary ignored");
        cmd(2'd0, 5'd11, 3'd0, 0, "R5 set reserved ignored");
        cmd(2'd1, 5'd24, 3'd0, 0, "R4 clear snan keeps VX via isi");
        cmd(2'd1, 5'd23, 3'd0, 0, "R4 clear isi drops VX");
        cmd(2'd2, 5'd0, 3'd0, 32'hFFFF_FFFF, "R7 R5 load all ones");
        cmd(2'd3, 5'd0, 3'd2, 0, "R8 copy field 2 hides reserved");
        cmd(2'd3, 5'd0, 3'd7, 0, "R8 copy field 7");
        cmd(2'd2, 5'd0, 3'd0, 32'h0, "R7 load zero");
        op(3'd0, 13'h0000, 3'd2, 1'b0, 1'b0, 1'b0, "R8 field holds");
        cmd(2'd0, 5'd25, 3'd0, 0, "R6 set inexact sets summary");
        cmd(2'd1, 5'd31, 3'd0, 0, "R7 clear summary");
        cmd(2'd0, 5'd25, 3'd0, 0, "R6 set already-set bit no summary");
        op(3'd0, 13'h0000, 3'd2, 1'b0, 1'b1, 1'b1, "R11 arith sets FR FI");
        op(3'd2, 13'h1FFF, 3'd4, 1'b1, 1'b0, 1'b0, "R9 select ignored");
        op(3'd7, 13'h1FFF, 3'd0, 1'b1, 1'b0, 1'b0, "R9 unused kind ignored");
        cmd(2'd2, 5'd0, 3'd0, 32'h0004_6000, "R7 load FR FI flags");
        op(3'd3, 13'h1200, 3'd2, 1'b0, 1'b1, 1'b1, "R10 round-int no inexact");
        op(3'd5, 13'h0100, 3'd2, 1'b1, 1'b1, 1'b0, "R12 float-to-int zero flags");
        op(3'd1, 13'h0010, 3'd4, 1'b0, 1'b1, 1'b1, "R13 special-case resets FR FI");
        drive(1'b1, 3'd0, 13'h0800, 3'd2, 1'b0, 1'b0, 1'b0,
              1'b1, 2'd0, 5'd4, 3'd0, 0, "R6 report and set same cycle");
        drive(1'b1, 3'd0, 13'h0400, 3'd2, 1'b0, 1'b0, 1'b0,
              1'b1, 2'd1, 5'd27, 3'd0, 0, "R6 command after report");
        for (int cl = 0; cl < 8; cl++) begin
            for (int ng = 0; ng < 2; ng++) begin
                op(3'd0, 13'h0000, 3'(cl), 1'(ng), 1'b0, 1'b0, "R14 flag code");
            end
        end
        cmd(2'd2, 5'd0, 3'd0, 32'h0, "R7 final load zero");
        drive(1'b0, 3'd0, 13'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0, 3'd0, 0, "R2 idle");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule